// File: doc/BRIEF.md
# Single-Wire Bus Slave Time-Slot Engine

This block is the signalling layer of a slave on a single-wire, open-drain bus whose idle level is high. It runs from a 1 MHz system clock, so one clock is one tick of 1 µs. The raw bus level passes through a two-flop synchronizer before any edge is detected. The block drives a pull-down enable for an external open-drain driver. Every action is timed from a falling edge that the master drives. A low that lasts long enough is a bus reset. The block answers it with a delayed presence pulse. In write slots it samples the master's bit. In read slots it sends a bit by holding the line low for a zero.

Toward the byte layer above, the block gives a one-cycle reset event and a bit handshake. The upper layer holds `slot_arm` high to take part in the next slot. With `slot_send` low, the slot is a receive, and the block returns the sampled level on `bit_rx` together with a `bit_done` pulse. With `slot_send` high, the slot is a transmit of `send_bit`, and `bit_done` marks the end of the hold window. The choice is latched at the falling edge. A slot that arrives while `slot_arm` is low is let pass.

The state machine has these states:
- `ST_IDLE`: waits for a falling edge.
- `ST_RX_SLOT`: counts to the sample point.
- `ST_TX_SLOT`: holds the line low for a zero.
- `ST_SLOT_TAIL`: waits for the line to return high.
- `ST_RST_LOW`: entered from any state when the long-low detector fires; waits for the line to rise.
- `ST_PRES_WAIT`: the delay before presence.
- `ST_PRES_LOW`: drives the presence pulse.

The transitions are:
- From `ST_IDLE` on a fall: to `ST_RX_SLOT`, `ST_TX_SLOT` or `ST_SLOT_TAIL`, chosen by arm and send.
- From `ST_RX_SLOT` and `ST_TX_SLOT` when the count expires: to `ST_SLOT_TAIL`.
- From `ST_SLOT_TAIL` when the line is high: to `ST_IDLE`.
- From any state when the reset is hit: to `ST_RST_LOW`.
- From `ST_RST_LOW` when the line rises: to `ST_PRES_WAIT`.
- From `ST_PRES_WAIT` after its delay: to `ST_PRES_LOW`.
- From `ST_PRES_LOW` after its length: to `ST_SLOT_TAIL`.

Top module: `owslv_engine`

## Requirements
- R1: After `rst_n` is released, `bus_pull`, `bus_reset` and `bit_done` are all 0.
- R2: A bus low of 480 or more consecutive ticks raises `bus_reset` for exactly one clock. A low of 400 ticks raises no `bus_reset` and no presence pulse.
- R3: After a reset low, `bus_pull` is 1 from 30 ticks after the line rises, for 120 ticks (1 = pull the line low). Ticks are counted at `bus_in`.
- R4: In an armed slot with `slot_send` = 0, the line level 30 ticks after the falling edge is returned on `bit_rx` (high = 1, low = 0) with a one-clock `bit_done` pulse. `bus_pull` stays 0 during the slot.
- R5: In an armed slot with `slot_send` = 1 and `send_bit` = 0, `bus_pull` is 1 from the falling edge for 30 ticks and 0 by 40 ticks. `bit_done` pulses once.
- R6: In an armed slot with `slot_send` = 1 and `send_bit` = 1, `bus_pull` stays 0 and `bit_done` pulses once.
- R7: A slot that starts while `slot_arm` = 0 yields no `bit_done` and no `bus_pull`, whatever `slot_send` is.
- R8: A low that reaches the reset length during a slot in progress cancels that slot. It raises `bus_reset` and leads to the presence pulse of R3.
- R9: One falling edge starts at most one slot. A low held beyond the slot yields one `bit_done` only, and the next slot needs the line to go high first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, one tick per µs |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 1 | Raw bus level, asynchronous |
| bus_pull | output | 1 | 1 enables the open-drain pull-down |
| bus_reset | output | 1 | One-clock pulse when a bus reset is detected |
| slot_arm | input | 1 | 1 = take part in the next slot |
| slot_send | input | 1 | 1 = next slot transmits, 0 = receives |
| send_bit | input | 1 | Bit value to transmit |
| bit_done | output | 1 | One-clock pulse when an armed slot finishes its bit |
| bit_rx | output | 1 | Sampled bit of the last receive slot |

## Verification
The bench releases the line at 25 and at 35 ticks after a falling edge. This brackets the 30-tick sample point, so a design that samples early or late returns the wrong bit. It holds the line low for 400 and for 500 ticks. A reset detector with the wrong threshold either misses the reset or fires on the shorter low. The presence pulse is probed just before and after its window, which exposes a wrong delay or a wrong length. It also runs a transmit slot that runs into a reset low and holds the line low past the slot. A design that does not give the reset priority would never present after that low. A design that retriggers on a held level would give a second `bit_done`.

// File: rtl/owslv_pkg.sv
package owslv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRES_WAIT,
        ST_PRES_LOW,
        ST_RX_SLOT,
        ST_TX_SLOT,
        ST_SLOT_TAIL,
        ST_RST_LOW
    } owslv_state_e;

    function automatic int owslv_max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/owslv_sync.sv
module owslv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic line_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= raw_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], raw_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign line_o = chain_q[STAGES-1];
    assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/owslv_low_timer.sv
module owslv_low_timer #(
    parameter int RESET_TICKS = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic hit_o
);
    localparam int CW = $clog2(RESET_TICKS + 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            hit_o <= 1'b0;
        end else begin
            hit_o <= 1'b0;
            if (line_i) begin
                run_q <= '0;
            end else if (run_q != CW'(RESET_TICKS)) begin
                run_q <= run_q + 1'b1;
                if (run_q == CW'(RESET_TICKS - 1)) hit_o <= 1'b1;
            end
        end
    end

    AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o); // R2
    AST_RESET_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(!line_i)); // R2

endmodule

// File: rtl/owslv_slot_fsm.sv
module owslv_slot_fsm
    import owslv_pkg::*;
#(
    parameter int PRES_WAIT = 30,
    parameter int PRES_LOW  = 120,
    parameter int SAMPLE_AT = 30,
    parameter int HOLD_ZERO = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic fall_i,
    input  logic rst_hit_i,
    input  logic arm_i,
    input  logic send_i,
    input  logic send_val_i,
    output logic pull_o,
    output logic done_o,
    output logic rx_o
);
    localparam int MAXT = owslv_max4(PRES_WAIT, PRES_LOW, SAMPLE_AT, HOLD_ZERO);
    localparam int CW   = $clog2(MAXT + 1);

    owslv_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          tx_q, tx_d;
    logic          fin;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        tx_d    = tx_q;
        fin     = 1'b0;
        if (rst_hit_i) begin
            state_d = ST_RST_LOW;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_d = '0;
                    if (fall_i) begin
                        if (!arm_i) begin
                            state_d = ST_SLOT_TAIL;
                        end else if (send_i) begin
                            state_d = ST_TX_SLOT;
                            tx_d    = send_val_i;
                        end else begin
                            state_d = ST_RX_SLOT;
                        end
                    end
                end
                ST_RST_LOW: begin
                    cnt_d = '0;
                    if (line_i) state_d = ST_PRES_WAIT;
                end
                ST_PRES_WAIT: begin
                    if (cnt_q == CW'(PRES_WAIT - 1)) begin
                        state_d = ST_PRES_LOW;
                        cnt_d   = '0;
                    end
                end
                ST_PRES_LOW: begin
                    if (cnt_q == CW'(PRES_LOW - 1)) begin
                        state_d = ST_SLOT_TAIL;
                        cnt_d   = '0;
                    end
                end
                ST_RX_SLOT: begin
                    if (cnt_q == CW'(SAMPLE_AT - 1)) begin
                        state_d = ST_SLOT_TAIL;
                        cnt_d   = '0;
                        fin     = 1'b1;
                    end
                end
                ST_TX_SLOT: begin
                    if (cnt_q == CW'(HOLD_ZERO - 1)) begin
                        state_d = ST_SLOT_TAIL;
                        cnt_d   = '0;
                        fin     = 1'b1;
                    end
                end
                ST_SLOT_TAIL: begin
                    cnt_d = '0;
                    if (line_i) state_d = ST_IDLE;
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tx_q    <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tx_q    <= tx_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            rx_o   <= 1'b1;
        end else begin
            done_o <= fin;
            if (fin && state_q == ST_RX_SLOT) rx_o <= line_i;
        end
    end

    assign pull_o = (state_q == ST_PRES_LOW) || (state_q == ST_TX_SLOT && !tx_q);

    AST_RESET_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hit_i |=> state_q == ST_RST_LOW); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4
    AST_PRES_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRES_WAIT && $past(state_q) == ST_RST_LOW) |-> $past(line_i)); // R3
    AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLOT_TAIL && $past(state_q) == ST_IDLE) |-> !done_o); // R7

endmodule

// File: rtl/owslv_engine.sv
module owslv_engine #(
    parameter int SYNC_STAGES = 2,
    parameter int RESET_TICKS = 480,
    parameter int PRES_WAIT   = 30,
    parameter int PRES_LOW    = 120,
    parameter int SAMPLE_AT   = 30,
    parameter int HOLD_ZERO   = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    output logic bus_pull,
    output logic bus_reset,
    input  logic slot_arm,
    input  logic slot_send,
    input  logic send_bit,
    output logic bit_done,
    output logic bit_rx
);
    logic line_s;
    logic fall_s;
    logic hit_s;

    owslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (bus_in),
        .line_o (line_s),
        .fall_o (fall_s)
    );

    owslv_low_timer #(.RESET_TICKS(RESET_TICKS)) u_low (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_s),
        .hit_o  (hit_s)
    );

    owslv_slot_fsm #(
        .PRES_WAIT (PRES_WAIT),
        .PRES_LOW  (PRES_LOW),
        .SAMPLE_AT (SAMPLE_AT),
        .HOLD_ZERO (HOLD_ZERO)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_s),
        .fall_i     (fall_s),
        .rst_hit_i  (hit_s),
        .arm_i      (slot_arm),
        .send_i     (slot_send),
        .send_val_i (send_bit),
        .pull_o     (bus_pull),
        .done_o     (bit_done),
        .rx_o       (bit_rx)
    );

    assign bus_reset = hit_s;

endmodule

// File: tb/owslv_engine_tb_top.sv
`timescale 1ns/1ps
module owslv_engine_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_low = 1'b0;
    logic bus_in;
    logic bus_pull, bus_reset, bit_done, bit_rx;
    logic slot_arm = 1'b0, slot_send = 1'b0, send_bit = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    int cnt_done = 0;
    int cnt_rst  = 0;
    logic last_rx = 1'b1;
    logic pull_any = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign bus_in = !(m_low || bus_pull);

    owslv_engine dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_in    (bus_in),
        .bus_pull  (bus_pull),
        .bus_reset (bus_reset),
        .slot_arm  (slot_arm),
        .slot_send (slot_send),
        .send_bit  (send_bit),
        .bit_done  (bit_done),
        .bit_rx    (bit_rx)
    );

    always @(negedge clk) begin
        if (bit_done) begin
            cnt_done = cnt_done + 1;
            last_rx  = bit_rx;
        end
        if (bus_reset) cnt_rst = cnt_rst + 1;
        if (bus_pull)  pull_any = 1'b1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        cnt_done = 0;
        cnt_rst  = 0;
        pull_any = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // {arm, send, val, low_ticks[9:0], exp_done, exp_rx, exp_pull_at_20}
    localparam logic [15:0] VEC [8] = '{
        {1'b1, 1'b0, 1'b0, 10'd5,  1'b1, 1'b1, 1'b0}, // R4 write one
        {1'b1, 1'b0, 1'b0, 10'd65, 1'b1, 1'b0, 1'b0}, // R4 write zero, R9 long low
        {1'b1, 1'b0, 1'b0, 10'd25, 1'b1, 1'b1, 1'b0}, // R4 release before sample
        {1'b1, 1'b0, 1'b0, 10'd35, 1'b1, 1'b0, 1'b0}, // R4 release after sample
        {1'b1, 1'b1, 1'b0, 10'd3,  1'b1, 1'b0, 1'b1}, // R5 send zero
        {1'b1, 1'b1, 1'b1, 10'd3,  1'b1, 1'b0, 1'b0}, // R6 send one
        {1'b0, 1'b0, 1'b0, 10'd5,  1'b0, 1'b0, 1'b0}, // R7 unarmed
        {1'b0, 1'b1, 1'b0, 10'd65, 1'b0, 1'b0, 1'b0}  // R7 unarmed, send set
    };

    task automatic run_slot(input logic arm, input logic snd, input logic val, input int low,
                            input logic e_done, input logic e_rx, input logic e_p20);
        string tag;
        logic p20, p40;
        p20 = 1'b0;
        p40 = 1'b0;
        if (!arm)       tag = "R7";
        else if (!snd)  tag = (low > 60) ? "R4 R9" : "R4";
        else if (!val)  tag = "R5";
        else            tag = "R6";
        @(negedge clk);
        slot_arm  = arm;
        slot_send = snd;
        send_bit  = val;
        clear_mon();
        m_low = 1'b1;
        for (int t = 1; t <= 110; t++) begin
            @(negedge clk);
            if (t == low) m_low = 1'b0;
            if (t == 20) p20 = bus_pull;
            if (t == 40) p40 = bus_pull;
        end
        ticks(10);
        check(cnt_done == int'(e_done), {tag, " done count"}, cnt_done, int'(e_done));
        if (e_done && !snd)
            check(last_rx == e_rx, {tag, " sampled bit"}, int'(last_rx), int'(e_rx));
        check(p20 == e_p20, {tag, " pull at 20"}, int'(p20), int'(e_p20));
        if (e_p20)
            check(p40 == 1'b0, {tag, " pull at 40"}, int'(p40), 0);
        else
            check(pull_any == 1'b0, {tag, " no pull in slot"}, int'(pull_any), 0);
        check(cnt_rst == 0, {tag, " no reset in slot"}, cnt_rst, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        ticks(5);
        // R1 reset state
        check(bus_pull == 1'b0, "R1 pull in reset", int'(bus_pull), 0);
        rst_n = 1'b1;
        ticks(5);
        check(bus_pull == 1'b0, "R1 pull after reset", int'(bus_pull), 0);
        check(bus_reset == 1'b0, "R1 reset event", int'(bus_reset), 0);
        check(bit_done == 1'b0, "R1 done", int'(bit_done), 0);

        // vector table
        for (int v = 0; v < 8; v++) begin
            run_slot(VEC[v][15], VEC[v][14], VEC[v][13], int'(VEC[v][12:3]),
                     VEC[v][2], VEC[v][1], VEC[v][0]);
        end

        // R2 short low: no reset, no presence
        slot_arm = 1'b0;
        clear_mon();
        m_low = 1'b1;
        ticks(400);
        m_low = 1'b0;
        ticks(200);
        check(cnt_rst == 0, "R2 short low reset", cnt_rst, 0);
        check(pull_any == 1'b0, "R2 short low presence", int'(pull_any), 0);

        // R2/R3 long low then presence
        clear_mon();
        m_low = 1'b1;
        ticks(500);
        check(cnt_rst == 1, "R2 reset pulse width", cnt_rst, 1);
        m_low = 1'b0;
        begin
            logic p20, p40, p140, p165;
            p20 = 0; p40 = 0; p140 = 0; p165 = 0;
            for (int t = 1; t <= 170; t++) begin
                @(negedge clk);
                if (t == 20)  p20  = bus_pull;
                if (t == 40)  p40  = bus_pull;
                if (t == 140) p140 = bus_pull;
                if (t == 165) p165 = bus_pull;
            end
            check(p20 == 1'b0, "R3 before presence", int'(p20), 0);
            check(p40 == 1'b1, "R3 presence start", int'(p40), 1);
            check(p140 == 1'b1, "R3 presence held", int'(p140), 1);
            check(p165 == 1'b0, "R3 presence end", int'(p165), 0);
        end
        ticks(20);

        // R8 reset during an armed transmit-zero slot
        slot_arm  = 1'b1;
        slot_send = 1'b1;
        send_bit  = 1'b0;
        clear_mon();
        m_low = 1'b1;
        ticks(20);
        check(bus_pull == 1'b1, "R8 slot started", int'(bus_pull), 1);
        ticks(580);
        check(cnt_rst == 1, "R8 reset during slot", cnt_rst, 1);
        m_low = 1'b0;
        ticks(40);
        check(bus_pull == 1'b1, "R8 presence after slot", int'(bus_pull), 1);
        ticks(150);

        // service resumes after reset
        run_slot(1'b1, 1'b0, 1'b0, 5, 1'b1, 1'b1, 1'b0);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule